// File: doc/BRIEF.md
# Half-Duplex Serial Flash Master

This block is a memory-mapped SPI master for serial flash devices. Software fills a 4-byte command word and up to eight 32-bit data words, programs three bit counts (command bits, outgoing data bits, incoming data bits), and then writes a start bit. The engine runs the three phases back to back on one SCK stream: the command word goes out first, then the outgoing data bits, and finally MISO is sampled into the same data words that supplied the outgoing bits. Software polls a busy flag to learn when the transfer is over.

SCK is the system clock divided by a programmable value from 2 to 4097. Only SPI mode 0 is produced: SCK idles low, MOSI changes as SCK falls, and MISO is sampled as SCK rises. Bit order within each byte is selectable. Each device has its own active-low select output, driven straight from a software register. The select therefore stays asserted across several transfers, so one flash command can span more than one buffer load.

Top module: `spi_flash_master`

## Requirements
- R1: Register map by byte address: 0x00 control/status, 0x04 command word, 0x08 to 0x24 data words 0 to 7, 0x28 configuration, 0x2C bit counts, 0x38 select. Configuration bits 27:16 hold the divider minus 2 and bit 3 is the LSB-first flag, and both read back. All other configuration bits, including 5:4, read as 0. Unmapped addresses read as 0.
- R2: Writing 1 to bit 8 of 0x00 while idle starts a transfer. Bit 16 of 0x00 then reads 1 for exactly N*D+1 system clocks, where N is the total bit count and D the divider, and clears one clock after the last bit ends.
- R3: The command phase sends the first C bits of the command word, byte 3 (bits 31:24) first, then byte 2, then byte 1, then byte 0. C comes from bits 29:24 of 0x2C and is limited to 32.
- R4: The outgoing data phase sends M bits from the data stream (M from bits 8:0 of 0x2C, limited to 256). Stream byte n is bits 8*(n%4)+7:8*(n%4) of data word n/4.
- R5: The receive phase samples R bits (R from bits 20:12 of 0x2C, limited to 256). Each bit is stored at the same stream position the outgoing phase would read. Bits not received keep their value. MOSI is 0 throughout this phase.
- R6: With configuration bit 3 at 0, bits within each byte travel from bit 7 down to bit 0. With bit 3 at 1, they travel from bit 0 up to bit 7. This applies to the command, outgoing and receive phases alike.
- R7: SCK is 0 while idle. Each bit lasts D system clocks: SCK is low for D - floor(D/2) clocks and then high for floor(D/2) clocks. MOSI does not change while SCK is high.
- R8: Phases run in the order command, outgoing, receive with no gap, and a phase with a zero count is skipped. A transfer gives exactly C+M+R rising SCK edges. With all counts zero, busy is high for one clock and SCK never toggles.
- R9: A start request while busy is ignored. Writes to the command, data, configuration and count registers while busy are ignored.
- R10: Select output cs_n_o[d] is the inverse of bit d of 0x38. It is unaffected by starting or finishing transfers.
- R11: After reset, busy is 0, SCK and MOSI are 0, every select output is 1, and every register reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bus_we_i | input | 1 | Register write strobe |
| bus_addr_i | input | 8 | Register byte address |
| bus_wdata_i | input | 32 | Register write data |
| bus_rdata_o | output | 32 | Register read data, combinational from the address |
| sck_o | output | 1 | SPI clock |
| mosi_o | output | 1 | Serial data to the device |
| miso_i | input | 1 | Serial data from the device |
| cs_n_o | output | NUM_CS | Per-device select, active low |

## Verification
The bench builds the block with NUM_CS set to 3, so that a select bit other than bit 0 and more than two devices can be checked, and with the default 12-bit divider field. It programs divider fields 0, 1, 2 and 3. These cover both even and odd divide values, which exercises the uneven split between the SCK low and high times. One transfer uses the full 256-bit outgoing and receive counts, so every data bit is both sent and overwritten. Other transfers use counts that end mid-byte, which checks that the bits outside the received range are left as they were.

// File: rtl/spi_fm_pkg.sv
`timescale 1ns/1ps
package spi_fm_pkg;
  localparam int DATA_WORDS = 8;
  localparam int DATA_BITS  = DATA_WORDS * 32;
  localparam int IDX_W      = $clog2(DATA_BITS);
  localparam int CNT_W      = IDX_W + 1;
  localparam int CMD_BITS   = 32;
  localparam int CCNT_W     = $clog2(CMD_BITS) + 1;
  localparam int DSEL_W     = $clog2(DATA_WORDS);

  // word addresses (byte address >> 2)
  localparam logic [5:0] W_TRANS = 6'h00;
  localparam logic [5:0] W_CMD   = 6'h01;
  localparam logic [5:0] W_DATA0 = 6'h02;
  localparam logic [5:0] W_CFG   = 6'h0A;
  localparam logic [5:0] W_CNT   = 6'h0B;
  localparam logic [5:0] W_CS    = 6'h0E;

  localparam int START_BIT  = 8;
  localparam int BUSY_BIT   = 16;
  localparam int DIV_LSB    = 16;
  localparam int LSBF_BIT   = 3;
  localparam int CCNT_LSB   = 24;
  localparam int RCNT_LSB   = 12;
  localparam int TCNT_LSB   = 0;

  typedef enum logic [1:0] {PH_CMD, PH_TX, PH_RX, PH_END} phase_e;

  function automatic logic [2:0] bit_pos(input logic [2:0] i, input logic lsb_first);
    return lsb_first ? i : ~i;
  endfunction
endpackage

// File: rtl/spi_fm_regs.sv
`timescale 1ns/1ps
module spi_fm_regs
  import spi_fm_pkg::*;
#(
  parameter int NUM_CS = 2,
  parameter int DIV_W  = 12
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 bus_we_i,
  input  logic [7:0]           bus_addr_i,
  input  logic [31:0]          bus_wdata_i,
  output logic [31:0]          bus_rdata_o,
  input  logic                 busy_i,
  input  logic                 rx_we_i,
  input  logic [IDX_W-1:0]     rx_idx_i,
  input  logic                 rx_bit_i,
  output logic                 start_o,
  output logic [CMD_BITS-1:0]  cmd_o,
  output logic [DATA_BITS-1:0] data_o,
  output logic [DIV_W-1:0]     div_o,
  output logic                 lsb_o,
  output logic [CCNT_W-1:0]    cmd_cnt_o,
  output logic [CNT_W-1:0]     tx_cnt_o,
  output logic [CNT_W-1:0]     rx_cnt_o,
  output logic [NUM_CS-1:0]    cs_o
);
  logic [5:0]           word;
  logic [5:0]           dsel;
  logic                 in_data;
  logic                 wr_ok;
  logic [CMD_BITS-1:0]  cmd_q;
  logic [DATA_BITS-1:0] data_q;
  logic [DIV_W-1:0]     div_q;
  logic                 lsb_q;
  logic [CCNT_W-1:0]    ccnt_q;
  logic [CNT_W-1:0]     tcnt_q, rcnt_q;
  logic [NUM_CS-1:0]    cs_q;

  assign word    = bus_addr_i[7:2];
  assign dsel    = word - W_DATA0;
  assign in_data = (word >= W_DATA0) && (word < W_DATA0 + 6'(DATA_WORDS));
  // config-type registers are frozen while a transfer runs
  assign wr_ok   = bus_we_i && !busy_i;
  assign start_o = bus_we_i && (word == W_TRANS) && bus_wdata_i[START_BIT];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cmd_q  <= '0;
      div_q  <= '0;
      lsb_q  <= 1'b0;
      ccnt_q <= '0;
      tcnt_q <= '0;
      rcnt_q <= '0;
      cs_q   <= '0;
    end else begin
      if (bus_we_i && word == W_CS) cs_q <= bus_wdata_i[NUM_CS-1:0];
      if (wr_ok) begin
        case (word)
          W_CMD: cmd_q <= bus_wdata_i;
          W_CFG: begin
            div_q <= bus_wdata_i[DIV_LSB +: DIV_W];
            lsb_q <= bus_wdata_i[LSBF_BIT];
          end
          W_CNT: begin
            ccnt_q <= bus_wdata_i[CCNT_LSB +: CCNT_W];
            rcnt_q <= bus_wdata_i[RCNT_LSB +: CNT_W];
            tcnt_q <= bus_wdata_i[TCNT_LSB +: CNT_W];
          end
          default: ;
        endcase
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      data_q <= '0;
    end else begin
      for (int k = 0; k < DATA_WORDS; k++) begin
        if (wr_ok && in_data && dsel[DSEL_W-1:0] == DSEL_W'(k))
          data_q[k*32 +: 32] <= bus_wdata_i;
      end
      if (rx_we_i) data_q[rx_idx_i] <= rx_bit_i;
    end
  end

  always_comb begin
    bus_rdata_o = '0;
    if (in_data) begin
      bus_rdata_o = data_q[{dsel[DSEL_W-1:0], 5'b0} +: 32];
    end else begin
      case (word)
        W_TRANS: bus_rdata_o[BUSY_BIT] = busy_i;
        W_CMD:   bus_rdata_o = cmd_q;
        W_CFG: begin
          bus_rdata_o[DIV_LSB +: DIV_W] = div_q;
          bus_rdata_o[LSBF_BIT]         = lsb_q;
        end
        W_CNT: begin
          bus_rdata_o[CCNT_LSB +: CCNT_W] = ccnt_q;
          bus_rdata_o[RCNT_LSB +: CNT_W]  = rcnt_q;
          bus_rdata_o[TCNT_LSB +: CNT_W]  = tcnt_q;
        end
        W_CS:    bus_rdata_o[NUM_CS-1:0] = cs_q;
        default: ;
      endcase
    end
  end

  assign cmd_o     = cmd_q;
  assign data_o    = data_q;
  assign div_o     = div_q;
  assign lsb_o     = lsb_q;
  assign cmd_cnt_o = ccnt_q;
  assign tx_cnt_o  = tcnt_q;
  assign rx_cnt_o  = rcnt_q;
  assign cs_o      = cs_q;

  // R9
  div_frozen_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_i && $past(busy_i) |-> $stable(div_q) && $stable(tcnt_q) && $stable(cmd_q));
endmodule

// File: rtl/spi_fm_sckgen.sv
`timescale 1ns/1ps
module spi_fm_sckgen #(
  parameter int DIV_W = 12
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [DIV_W-1:0] div_field_i,
  input  logic             run_i,
  output logic             sck_o,
  output logic             sample_o,
  output logic             bit_end_o
);
  localparam int TW = DIV_W + 1;

  logic [TW-1:0] div_q, tick_q, lo_len;

  assign lo_len    = div_q - (div_q >> 1);
  assign sck_o     = run_i && (tick_q >= lo_len);
  // last low clock: the following edge raises SCK and samples MISO
  assign sample_o  = run_i && (tick_q == lo_len - 1'b1);
  assign bit_end_o = run_i && (tick_q == div_q - 1'b1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      div_q  <= TW'(2);
      tick_q <= '0;
    end else begin
      if (load_i) div_q <= {1'b0, div_field_i} + TW'(2);
      if (!run_i || bit_end_o) tick_q <= '0;
      else                     tick_q <= tick_q + 1'b1;
    end
  end

  // R7
  tick_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_i |-> tick_q < div_q);
endmodule

// File: rtl/spi_fm_seq.sv
`timescale 1ns/1ps
module spi_fm_seq
  import spi_fm_pkg::*;
(
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 start_i,
  input  logic [CCNT_W-1:0]    cmd_cnt_i,
  input  logic [CNT_W-1:0]     tx_cnt_i,
  input  logic [CNT_W-1:0]     rx_cnt_i,
  input  logic                 lsb_i,
  input  logic [CMD_BITS-1:0]  cmd_i,
  input  logic [DATA_BITS-1:0] data_i,
  input  logic                 miso_i,
  input  logic                 sample_i,
  input  logic                 bit_end_i,
  output logic                 busy_o,
  output logic                 load_o,
  output logic                 run_o,
  output logic                 mosi_o,
  output logic                 rx_we_o,
  output logic [IDX_W-1:0]     rx_idx_o,
  output logic                 rx_bit_o
);
  phase_e            phase_q, first_ph, nxt_ph;
  logic              busy_q, lsb_q, last_bit;
  logic [CCNT_W-1:0] c_lim, cmd_n_q;
  logic [CNT_W-1:0]  t_lim, r_lim, tx_n_q, rx_n_q, cur_n, bit_q;
  logic [2:0]        pos;
  logic [IDX_W-1:0]  stream_idx;

  assign load_o = start_i && !busy_q;
  assign c_lim  = (cmd_cnt_i > CCNT_W'(CMD_BITS)) ? CCNT_W'(CMD_BITS) : cmd_cnt_i;
  assign t_lim  = (tx_cnt_i > CNT_W'(DATA_BITS)) ? CNT_W'(DATA_BITS) : tx_cnt_i;
  assign r_lim  = (rx_cnt_i > CNT_W'(DATA_BITS)) ? CNT_W'(DATA_BITS) : rx_cnt_i;

  always_comb begin
    if      (c_lim != '0) first_ph = PH_CMD;
    else if (t_lim != '0) first_ph = PH_TX;
    else if (r_lim != '0) first_ph = PH_RX;
    else                  first_ph = PH_END;

    case (phase_q)
      PH_CMD:  nxt_ph = (tx_n_q != '0) ? PH_TX : ((rx_n_q != '0) ? PH_RX : PH_END);
      PH_TX:   nxt_ph = (rx_n_q != '0) ? PH_RX : PH_END;
      default: nxt_ph = PH_END;
    endcase

    case (phase_q)
      PH_CMD:  cur_n = CNT_W'(cmd_n_q);
      PH_TX:   cur_n = tx_n_q;
      PH_RX:   cur_n = rx_n_q;
      default: cur_n = '0;
    endcase
  end

  assign last_bit = (bit_q + 1'b1) == cur_n;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q  <= 1'b0;
      phase_q <= PH_END;
      bit_q   <= '0;
      cmd_n_q <= '0;
      tx_n_q  <= '0;
      rx_n_q  <= '0;
      lsb_q   <= 1'b0;
    end else if (load_o) begin
      busy_q  <= 1'b1;
      phase_q <= first_ph;
      bit_q   <= '0;
      cmd_n_q <= c_lim;
      tx_n_q  <= t_lim;
      rx_n_q  <= r_lim;
      lsb_q   <= lsb_i;
    end else if (busy_q) begin
      if (phase_q == PH_END) begin
        busy_q <= 1'b0;
      end else if (bit_end_i) begin
        if (last_bit) begin
          bit_q   <= '0;
          phase_q <= nxt_ph;
        end else begin
          bit_q <= bit_q + 1'b1;
        end
      end
    end
  end

  assign pos        = bit_pos(bit_q[2:0], lsb_q);
  assign stream_idx = {bit_q[IDX_W-1:3], pos};

  always_comb begin
    case (phase_q)
      // command word leaves highest byte first
      PH_CMD:  mosi_o = cmd_i[{~bit_q[4:3], pos}];
      PH_TX:   mosi_o = data_i[stream_idx];
      default: mosi_o = 1'b0;
    endcase
  end

  assign busy_o   = busy_q;
  assign run_o    = busy_q && (phase_q != PH_END);
  assign rx_we_o  = (phase_q == PH_RX) && sample_i;
  assign rx_idx_o = stream_idx;
  assign rx_bit_o = miso_i;

  // R9
  start_ignored_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_q && start_i |=> $stable(cmd_n_q) && $stable(tx_n_q) && $stable(rx_n_q));
  // R2
  busy_drop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_q && phase_q == PH_END && !start_i |=> !busy_q);
  // R8
  phase_order_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_q && phase_q != PH_END |=> busy_q && phase_q >= $past(phase_q));
endmodule

// File: rtl/spi_flash_master.sv
`timescale 1ns/1ps
module spi_flash_master
  import spi_fm_pkg::*;
#(
  parameter int NUM_CS = 2,
  parameter int DIV_W  = 12
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              bus_we_i,
  input  logic [7:0]        bus_addr_i,
  input  logic [31:0]       bus_wdata_i,
  output logic [31:0]       bus_rdata_o,
  output logic              sck_o,
  output logic              mosi_o,
  input  logic              miso_i,
  output logic [NUM_CS-1:0] cs_n_o
);
  logic                 busy, start, load, run, sample, bit_end;
  logic                 rx_we, rx_bit, lsb;
  logic [IDX_W-1:0]     rx_idx;
  logic [CMD_BITS-1:0]  cmd;
  logic [DATA_BITS-1:0] data;
  logic [DIV_W-1:0]     div_field;
  logic [CCNT_W-1:0]    ccnt;
  logic [CNT_W-1:0]     tcnt, rcnt;
  logic [NUM_CS-1:0]    cs;

  spi_fm_regs #(.NUM_CS(NUM_CS), .DIV_W(DIV_W)) regs_i (
    .clk_i, .rst_ni, .bus_we_i, .bus_addr_i, .bus_wdata_i, .bus_rdata_o,
    .busy_i(busy), .rx_we_i(rx_we), .rx_idx_i(rx_idx), .rx_bit_i(rx_bit),
    .start_o(start), .cmd_o(cmd), .data_o(data), .div_o(div_field), .lsb_o(lsb),
    .cmd_cnt_o(ccnt), .tx_cnt_o(tcnt), .rx_cnt_o(rcnt), .cs_o(cs)
  );

  spi_fm_sckgen #(.DIV_W(DIV_W)) sckgen_i (
    .clk_i, .rst_ni, .load_i(load), .div_field_i(div_field), .run_i(run),
    .sck_o, .sample_o(sample), .bit_end_o(bit_end)
  );

  spi_fm_seq seq_i (
    .clk_i, .rst_ni, .start_i(start), .cmd_cnt_i(ccnt), .tx_cnt_i(tcnt),
    .rx_cnt_i(rcnt), .lsb_i(lsb), .cmd_i(cmd), .data_i(data), .miso_i,
    .sample_i(sample), .bit_end_i(bit_end), .busy_o(busy), .load_o(load),
    .run_o(run), .mosi_o, .rx_we_o(rx_we), .rx_idx_o(rx_idx), .rx_bit_o(rx_bit)
  );

  assign cs_n_o = ~cs;

  // R7
  sck_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy |-> !sck_o);
  // R7
  mosi_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sck_o && $past(sck_o) |-> $stable(mosi_o));
  // R5
  rx_mosi_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_we |-> !mosi_o);
endmodule

// File: tb/spi_flash_master_tb.sv
`timescale 1ns/1ps
module spi_flash_master_tb_top;
  localparam int NCS = 3;

  logic clk = 1'b0, rst_ni = 1'b0;
  logic bus_we = 1'b0;
  logic [7:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0, bus_rdata;
  logic sck, mosi, miso = 1'b0;
  logic [NCS-1:0] cs_n;

  int n_cmp = 0, n_bad = 0;
  logic exp_q[$];
  logic [1023:0] pat;
  int edges = 0, hi_cnt = 0;
  logic [NCS-1:0] exp_cs_n = '1;
  logic [255:0] flat_exp;
  logic done = 1'b0;

  always #4 clk = ~clk;

  spi_flash_master #(.NUM_CS(NCS)) dut_i (
    .clk_i(clk), .rst_ni, .bus_we_i(bus_we), .bus_addr_i(bus_addr),
    .bus_wdata_i(bus_wdata), .bus_rdata_o(bus_rdata), .sck_o(sck),
    .mosi_o(mosi), .miso_i(miso), .cs_n_o(cs_n)
  );

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  // monitor: each rising SCK pops one expected MOSI bit
  always @(posedge sck) begin
    #2;
    check("R10 select during transfer", 64'(cs_n), 64'(exp_cs_n));
    if (exp_q.size() == 0) check("R8 extra SCK edge", 1, 0);
    else check("R3/R4/R5 mosi bit", 64'(mosi), 64'(exp_q.pop_front()));
  end

  // device model: next MISO bit after each falling SCK
  always @(negedge sck) begin
    #1;
    edges++;
    miso = pat[edges];
  end

  always @(negedge clk) if (sck) hi_cnt++;

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = a;
    #1 d = bus_rdata;
  endtask

  function automatic int pos(input int i, input logic lsb);
    return lsb ? (i % 8) : (7 - (i % 8));
  endfunction

  task automatic run_txn(input logic [31:0] cmd, input int c, input int m, input int r,
                         input int field, input logic lsb, input logic poke);
    int div, n, cyc;
    logic [31:0] v;
    div = field + 2;
    n = c + m + r;
    wr(8'h28, (32'(field) << 16) | (32'(lsb) << 3));
    wr(8'h04, cmd);
    wr(8'h2C, (32'(c) << 24) | (32'(r) << 12) | 32'(m));
    for (int k = 0; k < 8; k++) wr(8'(8 + 4*k), flat_exp[k*32 +: 32]);
    for (int i = 0; i < c; i++) exp_q.push_back(cmd[(3 - i/8)*8 + pos(i, lsb)]);
    for (int i = 0; i < m; i++) exp_q.push_back(flat_exp[(i/8)*8 + pos(i, lsb)]);
    for (int i = 0; i < r; i++) exp_q.push_back(1'b0);
    for (int i = 0; i < 1024; i++) pat[i] = $urandom_range(0, 1);
    edges = 0; miso = pat[0]; hi_cnt = 0;
    @(negedge clk);
    bus_we = 1'b1; bus_addr = 8'h00; bus_wdata = 32'h100;
    cyc = 0;
    forever begin
      @(negedge clk);
      bus_we = 1'b0; bus_addr = 8'h00;
      #1;
      if (!bus_rdata[16]) break;
      cyc++;
      if (poke) begin
        // R9: writes issued while busy
        if (cyc == 4) begin bus_we = 1'b1; bus_addr = 8'h00; bus_wdata = 32'h100; end
        if (cyc == 5) begin bus_we = 1'b1; bus_addr = 8'h08; bus_wdata = 32'hDEADBEEF; end
        if (cyc == 6) begin bus_we = 1'b1; bus_addr = 8'h2C; bus_wdata = 32'h0; end
        if (cyc == 7) begin bus_we = 1'b1; bus_addr = 8'h28; bus_wdata = 32'h00050008; end
      end
    end
    check("R2 busy length", 64'(cyc), 64'(n*div + 1));
    check("R8 all expected SCK edges seen", 64'(exp_q.size()), 0);
    exp_q.delete();
    check("R7 SCK high time", 64'(hi_cnt), 64'(n*(div/2)));
    check("R7 SCK idle low", 64'(sck), 0);
    for (int j = 0; j < r; j++) flat_exp[(j/8)*8 + pos(j, lsb)] = pat[c + m + j];
    for (int k = 0; k < 8; k++) begin
      rd(8'(8 + 4*k), v);
      check("R5 data word after transfer", 64'(v), 64'(flat_exp[k*32 +: 32]));
    end
    if (poke) begin
      rd(8'h2C, v);
      check("R9 count reg kept", 64'(v), 64'((32'(c) << 24) | (32'(r) << 12) | 32'(m)));
      rd(8'h28, v);
      check("R9 config kept", 64'(v), 64'((32'(field) << 16) | (32'(lsb) << 3)));
    end
    check("R10 select held after transfer", 64'(cs_n), 64'(exp_cs_n));
  endtask

  initial begin
    logic [31:0] v;
    for (int k = 0; k < 8; k++) flat_exp[k*32 +: 32] = 32'hA5C3_0F10 + 32'(k) * 32'h0103_0507;
    repeat (3) @(negedge clk);
    // R11 reset state
    check("R11 select idle", 64'(cs_n), 64'({NCS{1'b1}}));
    check("R11 SCK low", 64'(sck), 0);
    check("R11 MOSI low", 64'(mosi), 0);
    rd(8'h00, v); check("R11 status", 64'(v), 0);
    rd(8'h2C, v); check("R11 counts", 64'(v), 0);
    rst_ni = 1'b1;
    rd(8'h00, v); check("R11 status after release", 64'(v), 0);
    rd(8'h08, v); check("R11 data word 0", 64'(v), 0);
    // R1 configuration readback, reserved bits 5:4 read 0
    wr(8'h28, 32'hFFFF_FFFF);
    rd(8'h28, v); check("R1 config readback", 64'(v), 64'h0FFF_0008);
    rd(8'h40, v); check("R1 unmapped reads 0", 64'(v), 0);
    // R10 select mapping
    wr(8'h38, 32'h2);
    exp_cs_n = 3'b101;
    check("R10 select bit 1", 64'(cs_n), 64'(exp_cs_n));
    // R3 R4: full command word then data, MSB-first, divide 2
    run_txn(32'h9F12_34C5, 32, 24, 0, 0, 1'b0, 1'b0);
    // R5: command then receive, odd divide 3
    run_txn(32'h0300_0000, 8, 0, 16, 1, 1'b0, 1'b0);
    // R6: LSB-first, partial bytes, no command phase
    run_txn(32'h0, 0, 12, 20, 2, 1'b1, 1'b0);
    // R6: LSB-first command word
    run_txn(32'hC3A5_7E18, 16, 0, 0, 0, 1'b1, 1'b0);
    // R8: all counts zero
    run_txn(32'h0, 0, 0, 0, 0, 1'b0, 1'b0);
    // R9: writes and restart while busy
    run_txn(32'hAB00_0000, 8, 16, 0, 3, 1'b0, 1'b1);
    // R4 R5: full buffer both directions
    run_txn(32'h0B00_0000, 8, 256, 256, 0, 1'b0, 1'b0);
    wr(8'h38, 32'h0);
    exp_cs_n = 3'b111;
    check("R10 select released", 64'(cs_n), 64'(exp_cs_n));
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog expired act=running exp=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule